// File: doc/BRIEF.md
# USB Bus Line State Monitor

This block watches the two data wires of a USB link, which arrive already synchronised to the local clock, and takes one sample per bit time when the `bit_tick` strobe is high. Each sample is classified as single-ended zero, J, K or single-ended one. The classification uses a speed-select input, because the J and K differential states swap polarity between full and low speed. From the sequence of samples the block recognises the start and end of packets, keep-alive markers, bus reset, suspend and resume. Durations are measured by counting bit-time ticks against parameter thresholds.

A state machine with six states drives the outputs. `ST_IDLE` counts consecutive J samples. `ST_ACTIVE` covers packet traffic and any K or SE1 seen outside a wake-up. `ST_SE0` counts consecutive SE0 samples. `ST_RESET` holds while the reset condition lasts. `ST_SUSPEND` holds while the idle bus stays in J. `ST_WAKE` counts K samples after suspend.

The transitions are as follows. From `ST_IDLE`, K goes to `ST_ACTIVE` and raises a start-of-packet pulse, and the J sample that completes `SUSP_TICKS` goes to `ST_SUSPEND`. From any state other than `ST_RESET`, SE0 enters `ST_SE0`. From `ST_SE0`, J returns to `ST_IDLE`, and an end-of-packet pulse is raised when exactly two SE0 samples came before it. The SE0 sample that completes `RST_TICKS` goes from `ST_SE0` to `ST_RESET`. From `ST_SUSPEND`, K goes to `ST_WAKE`. J from `ST_ACTIVE`, `ST_RESET` or `ST_WAKE` returns to `ST_IDLE`. K or SE1 from `ST_SE0` or `ST_RESET` goes to `ST_ACTIVE`.

Top module: `usb_line_mon`

## Requirements
- R1: On each cycle with `bit_tick` high the pins are decoded into `line_state`. Both pins low gives 00 (SE0) and both high gives 11 (SE1). With `low_speed` low, `dp`=1/`dm`=0 gives 01 (J) and the opposite pair gives 10 (K). With `low_speed` high the two differential codes are swapped.
- R2: `line_state` and all flags change only after a sampled tick. Pin values present in cycles without `bit_tick` have no effect.
- R3: A K sample that directly follows a J sample (not while suspended) raises `sop_pulse` for one cycle.
- R4: A J sample that follows exactly two consecutive SE0 samples raises `eop_pulse` for one cycle. SE0 runs of any other length raise no pulse.
- R5: `keepalive_pulse` accompanies `eop_pulse` only when `low_speed` is high at the J sample.
- R6: `bus_reset` rises after the `RST_TICKS`-th consecutive SE0 sample and falls at the first sample that is not SE0.
- R7: `suspended` rises after `SUSP_TICKS` consecutive J samples and falls at any sample other than J. Any SE0 sample, including a keep-alive, restarts the count.
- R8: While suspended, a run of `RESUME_TICKS` consecutive K samples raises `resume_pulse` once, on the last sample of that run. A K sample that wakes the bus raises no `sop_pulse`.
- R9: While suspended, an SE0 run still reaches `bus_reset` after `RST_TICKS` samples.
- R10: Every SE1 sample raises `se1_err` for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| dp | input | 1 | Synchronised D+ level |
| dm | input | 1 | Synchronised D- level |
| low_speed | input | 1 | 1 = low-speed polarity |
| line_state | output | 2 | Last decoded sample (00 SE0, 01 J, 10 K, 11 SE1) |
| sop_pulse | output | 1 | Start of packet |
| eop_pulse | output | 1 | End of packet |
| keepalive_pulse | output | 1 | Low-speed end of packet |
| resume_pulse | output | 1 | Resume recognised |
| se1_err | output | 1 | Invalid SE1 sample |
| bus_reset | output | 1 | Reset condition level |
| suspended | output | 1 | Suspend level |

## Verification
A wrong counter value or state is visible at the ports within a few ticks. The bench sweeps the length of each run of one symbol and checks that the flag rises on exactly the threshold sample. An off-by-one error in a count therefore shows as a `bus_reset`, `suspended` or `resume_pulse` one sample early or late. It also shows as an end-of-packet pulse on an SE0 run of the wrong length. A state machine stuck in the wrong state gives a missing or spurious `sop_pulse` on the next K sample. The gap cycle after each tick drives the pins to SE1, so any sampling on a cycle without a tick shows up as a changed `line_state` in that cycle.

// File: rtl/usb_lm_pkg.sv
package usb_lm_pkg;

    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_J   = 2'b01,
        LS_K   = 2'b10,
        LS_SE1 = 2'b11
    } line_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACTIVE,
        ST_SE0,
        ST_RESET,
        ST_SUSPEND,
        ST_WAKE
    } mon_st_t;

endpackage

// File: rtl/usb_lm_decode.sv
module usb_lm_decode
    import usb_lm_pkg::*;
(
    input  logic  dp,
    input  logic  dm,
    input  logic  low_speed,
    output line_t code
);

    always_comb begin
        unique case ({dp, dm})
            2'b00:   code = LS_SE0;
            2'b11:   code = LS_SE1;
            2'b10:   code = low_speed ? LS_K : LS_J;
            default: code = low_speed ? LS_J : LS_K;
        endcase
    end

endmodule

// File: rtl/usb_lm_span.sv
module usb_lm_span #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_one,
    input  logic          step,
    output logic [CW-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load_one)
            cnt <= CW'(1);
        else if (step)
            cnt <= cnt + CW'(1);
    end

endmodule

// File: rtl/usb_line_mon.sv
module usb_line_mon
    import usb_lm_pkg::*;
#(
    parameter int RST_TICKS    = 30,
    parameter int SUSP_TICKS   = 36000,
    parameter int RESUME_TICKS = 240000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_tick,
    input  logic       dp,
    input  logic       dm,
    input  logic       low_speed,
    output logic [1:0] line_state,
    output logic       sop_pulse,
    output logic       eop_pulse,
    output logic       keepalive_pulse,
    output logic       resume_pulse,
    output logic       se1_err,
    output logic       bus_reset,
    output logic       suspended
);

    localparam int MAX_A = (RST_TICKS > SUSP_TICKS) ? RST_TICKS : SUSP_TICKS;
    localparam int MAX_T = (MAX_A > RESUME_TICKS) ? MAX_A : RESUME_TICKS;
    localparam int CW    = $clog2(MAX_T + 1);
    localparam logic [CW-1:0] RST_LAST  = CW'(RST_TICKS - 1);
    localparam logic [CW-1:0] SUSP_LAST = CW'(SUSP_TICKS - 1);
    localparam logic [CW-1:0] RES_LAST  = CW'(RESUME_TICKS - 1);
    localparam logic [CW-1:0] EOP_LEN   = CW'(2);

    line_t          cur;
    mon_st_t        st, nxt;
    logic [CW-1:0]  cnt;
    logic           ld, stp;
    logic           ev_sop, ev_eop, ev_res;

    usb_lm_decode u_dec (
        .dp        (dp),
        .dm        (dm),
        .low_speed (low_speed),
        .code      (cur)
    );

    usb_lm_span #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_one (ld),
        .step     (stp),
        .cnt      (cnt)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // next state and event decisions
    always_comb begin
        nxt    = st;
        ld     = 1'b0;
        stp    = 1'b0;
        ev_sop = 1'b0;
        ev_eop = 1'b0;
        ev_res = 1'b0;
        if (bit_tick) begin
            unique case (st)
                ST_IDLE: begin
                    unique case (cur)
                        LS_J:   if (cnt == SUSP_LAST) nxt = ST_SUSPEND; else stp = 1'b1;
                        LS_K:   begin nxt = ST_ACTIVE; ev_sop = 1'b1; end
                        LS_SE0: begin nxt = ST_SE0; ld = 1'b1; end
                        LS_SE1: nxt = ST_ACTIVE;
                    endcase
                end
                ST_ACTIVE: begin
                    unique case (cur)
                        LS_J:   begin nxt = ST_IDLE; ld = 1'b1; end
                        LS_SE0: begin nxt = ST_SE0;  ld = 1'b1; end
                        default: nxt = ST_ACTIVE;
                    endcase
                end
                ST_SE0: begin
                    unique case (cur)
                        LS_SE0: if (cnt == RST_LAST) nxt = ST_RESET; else stp = 1'b1;
                        LS_J:   begin nxt = ST_IDLE; ld = 1'b1; ev_eop = (cnt == EOP_LEN); end
                        default: nxt = ST_ACTIVE;
                    endcase
                end
                ST_RESET: begin
                    unique case (cur)
                        LS_SE0: nxt = ST_RESET;
                        LS_J:   begin nxt = ST_IDLE; ld = 1'b1; end
                        default: nxt = ST_ACTIVE;
                    endcase
                end
                ST_SUSPEND: begin
                    unique case (cur)
                        LS_J:   nxt = ST_SUSPEND;
                        LS_K:   begin nxt = ST_WAKE; ld = 1'b1; ev_res = (RESUME_TICKS == 1); end
                        LS_SE0: begin nxt = ST_SE0;  ld = 1'b1; end
                        LS_SE1: nxt = ST_ACTIVE;
                    endcase
                end
                ST_WAKE: begin
                    unique case (cur)
                        LS_K: begin
                            if (cnt < CW'(RESUME_TICKS)) begin
                                stp    = 1'b1;
                                ev_res = (cnt == RES_LAST);
                            end
                        end
                        LS_J:   begin nxt = ST_IDLE; ld = 1'b1; end
                        LS_SE0: begin nxt = ST_SE0;  ld = 1'b1; end
                        LS_SE1: nxt = ST_ACTIVE;
                    endcase
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_state      <= LS_J;
            sop_pulse       <= 1'b0;
            eop_pulse       <= 1'b0;
            keepalive_pulse <= 1'b0;
            resume_pulse    <= 1'b0;
            se1_err         <= 1'b0;
        end else begin
            sop_pulse       <= ev_sop;
            eop_pulse       <= ev_eop;
            keepalive_pulse <= ev_eop & low_speed;
            resume_pulse    <= ev_res;
            se1_err         <= bit_tick && (cur == LS_SE1);
            if (bit_tick) line_state <= cur;
        end
    end

    assign bus_reset = (st == ST_RESET);
    assign suspended = (st == ST_SUSPEND);

    // R2
    ls_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_tick) |-> $stable(line_state));
    // R2
    pulse_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sop_pulse || eop_pulse || resume_pulse || se1_err) |-> $past(bit_tick));
    // R3
    sop_on_k_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sop_pulse |-> line_state == LS_K);
    // R4
    eop_on_j_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eop_pulse |-> line_state == LS_J);
    // R5
    ka_with_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        keepalive_pulse |-> eop_pulse);
    // R6
    reset_on_se0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |-> line_state == LS_SE0);
    // R7
    susp_on_j_chk: assert property (@(posedge clk) disable iff (!rst_n)
        suspended |-> (line_state == LS_J && !bus_reset));
    // R8
    resume_on_k_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resume_pulse |-> (line_state == LS_K && !sop_pulse));
    // R10
    se1_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        se1_err |-> line_state == LS_SE1);

endmodule

// File: tb/tb_usb_line_mon.sv
module tb_usb_line_mon;

    localparam int RT = 6;
    localparam int ST = 12;
    localparam int WT = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_tick = 1'b0;
    logic dp = 1'b1, dm = 1'b0, low_speed = 1'b0;
    logic [1:0] line_state;
    logic sop_pulse, eop_pulse, keepalive_pulse, resume_pulse, se1_err, bus_reset, suspended;

    int n_chk = 0;
    int n_fail = 0;
    logic [1:0] c_ls;
    logic c_sop, c_eop, c_ka, c_res, c_se1, c_rst, c_susp;

    always #2.5 clk = ~clk;

    usb_line_mon #(.RST_TICKS(RT), .SUSP_TICKS(ST), .RESUME_TICKS(WT)) dut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .dp(dp), .dm(dm),
        .low_speed(low_speed), .line_state(line_state), .sop_pulse(sop_pulse),
        .eop_pulse(eop_pulse), .keepalive_pulse(keepalive_pulse),
        .resume_pulse(resume_pulse), .se1_err(se1_err), .bus_reset(bus_reset),
        .suspended(suspended)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // symbol codes: 0 SE0, 1 J, 2 K, 3 SE1
    task automatic send(input int sym);
        @(negedge clk);
        case (sym)
            0: {dp, dm} = 2'b00;
            3: {dp, dm} = 2'b11;
            1: {dp, dm} = low_speed ? 2'b01 : 2'b10;
            default: {dp, dm} = low_speed ? 2'b10 : 2'b01;
        endcase
        bit_tick = 1'b1;
        @(negedge clk);
        c_ls = line_state; c_sop = sop_pulse; c_eop = eop_pulse; c_ka = keepalive_pulse;
        c_res = resume_pulse; c_se1 = se1_err; c_rst = bus_reset; c_susp = suspended;
        bit_tick = 1'b0;
        {dp, dm} = (sym == 3) ? 2'b00 : 2'b11;
        @(negedge clk);
        // R2: gap cycle pins ignored, pulses last one cycle
        chk(line_state == c_ls && bus_reset == c_rst && suspended == c_susp, "R2 hold",
            line_state, c_ls);
        chk(!(sop_pulse || eop_pulse || resume_pulse || se1_err || keepalive_pulse),
            "R2 pulse width", int'(sop_pulse | eop_pulse | resume_pulse | se1_err), 0);
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(line_state == 2'b01 && !bus_reset && !suspended && !sop_pulse, "R1 reset state",
            line_state, 1);
        rst_n = 1'b1;

        // R1 decode with both polarities
        for (int s = 0; s < 2; s++) begin
            low_speed = s[0];
            for (int p = 0; p < 4; p++) begin
                @(negedge clk);
                {dp, dm} = p[1:0];
                bit_tick = 1'b1;
                @(negedge clk);
                bit_tick = 1'b0;
                chk(line_state == ((p == 0) ? 2'd0 : (p == 3) ? 2'd3 :
                                   ((p == 2) ^ s[0]) ? 2'd1 : 2'd2),
                    "R1 decode", line_state, p);
                // R10
                chk(se1_err == (p == 3), "R10 se1", se1_err, int'(p == 3));
            end
        end
        send(2);

        // R4 R5 R6 sweep of SE0 run length, both speeds
        for (int s = 0; s < 2; s++) begin
            low_speed = s[0];
            for (int n = 1; n <= RT + 2; n++) begin
                for (int i = 1; i <= n; i++) begin
                    send(0);
                    chk(c_rst == (i >= RT), "R6 reset rise", c_rst, int'(i >= RT));
                end
                send(1);
                chk(c_eop == (n == 2), "R4 eop", c_eop, int'(n == 2));
                chk(c_ka == (n == 2 && s == 1), "R5 keepalive", c_ka, int'(n == 2 && s == 1));
                chk(!c_rst, "R6 reset fall", c_rst, 0);
                send(2);
                chk(c_sop, "R3 sop after J", c_sop, 1);
            end
        end

        // R7 R8 idle length sweep with resume
        low_speed = 1'b0;
        for (int m = ST - 2; m <= ST + 2; m++) begin
            for (int i = 1; i <= m; i++) begin
                send(1);
                chk(c_susp == (i >= ST), "R7 suspend rise", c_susp, int'(i >= ST));
            end
            send(2);
            chk(c_sop == (m < ST), "R8 no sop on wake", c_sop, int'(m < ST));
            chk(!c_susp, "R7 suspend fall", c_susp, 0);
            if (m >= ST) begin
                chk(c_res == (WT == 1), "R8 resume k1", c_res, 0);
                for (int j = 2; j <= WT + 2; j++) begin
                    send(2);
                    chk(c_res == (j == WT), "R8 resume", c_res, int'(j == WT));
                end
                send(1);
                send(2);
                chk(c_sop, "R3 sop after resume", c_sop, 1);
            end
        end

        // R7 keep-alive restarts idle count
        low_speed = 1'b1;
        send(1);
        for (int i = 0; i < ST - 2; i++) send(1);
        send(0); send(0); send(1);
        chk(c_ka && c_eop, "R5 keepalive event", c_ka, 1);
        for (int i = 0; i < ST - 2; i++) begin
            send(1);
            chk(!c_susp, "R7 restart", c_susp, 0);
        end

        // R9 reset while suspended
        for (int i = 0; i < ST; i++) send(1);
        chk(c_susp, "R9 suspended first", c_susp, 1);
        for (int i = 1; i <= RT; i++) begin
            send(0);
            chk(c_rst == (i >= RT) && !c_susp, "R9 reset in suspend", c_rst, int'(i >= RT));
        end
        send(3);
        chk(c_se1 && c_ls == 2'd3 && !c_rst, "R10 se1 ends reset", c_ls, 3);
        send(2);
        chk(!c_sop, "R3 no sop from K after SE1", c_sop, 0);

        report();
    end

endmodule